// File: doc/BRIEF.md
# Software Trap Interrupt Arbiter

This block sits beside the instruction register of a small microcontroller core. It watches every load of the instruction register. When the loaded opcode is the reserved trap opcode, which is the same opcode used to acknowledge interrupts, it raises a non-maskable software trap. The opcode can reach the register when the program counter runs past the end of program memory, or when the stack is popped too many times.

The trap is held in a pending bit that software cannot read. This bit does not change the global interrupt enable. While it is set, every maskable request is shut out, and an interrupt vector request always returns the trap routine's index. Software clears the bit with a dedicated pending-clear strobe, and reset also clears it.

When no trap is pending, the arbiter grants the lowest-numbered active maskable request, provided the global enable is set. Vector index 0 is reserved for the trap, so maskable source i is presented as index i+1.

Top module: `strap_arbiter`

## Requirements
- R1: After reset, trapPending, intTaken and vecIndex are all 0.
- R2: If irLoad is high on a clock edge while irData equals TRAP_OPCODE (default 8'h00), trapPending is 1 from that edge onward.
- R3: A trap opcode on irData has no effect on trapPending when irLoad is low. Any other opcode loaded with irLoad high also has no effect.
- R4: trapPending holds until pendClr is sampled high. It is 0 after that edge.
- R5: If a trap load and pendClr are sampled on the same edge, trapPending stays 1.
- R6: A vecReq sampled while trapPending is 1 gives intTaken=1 and vecIndex=0 after that edge. This holds whatever the values of globalEn and intReq.
- R7: A vecReq sampled with trapPending=0, globalEn=1 and at least one intReq bit set gives intTaken=1 and vecIndex = i+1 after that edge, where i is the lowest set bit of intReq.
- R8: A vecReq sampled with trapPending=0 and globalEn=0 gives intTaken=0 and vecIndex=0, even when requests are active.
- R9: A vecReq sampled with trapPending=0 and intReq all zero gives intTaken=0 and vecIndex=0.
- R10: intTaken is 0 after any edge on which vecReq was low. intTaken is therefore a single-cycle pulse per request.
- R11: A new trap load while trapPending is already 1 keeps it at 1. A trap is raised with globalEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irData | input | OPC_W | Opcode being loaded into the instruction register |
| irLoad | input | 1 | Instruction register load strobe |
| intReq | input | NUM_REQ | Maskable interrupt requests, bit 0 has the highest priority |
| globalEn | input | 1 | Global interrupt enable |
| vecReq | input | 1 | Vector request strobe |
| pendClr | input | 1 | Trap pending clear strobe |
| trapPending | output | 1 | Trap pending flag |
| intTaken | output | 1 | One-cycle pulse: an interrupt was granted |
| vecIndex | output | VEC_W | Granted vector: 0 for the trap, i+1 for request i |

## Verification
A pending bit that is stuck or lost shows up on trapPending one edge after the faulty load or clear. It also shows up at the next vector request, as a trap grant with index 0 where a maskable index was expected, or the reverse. A fault in the priority encoder appears as a wrong vecIndex on the edge after vecReq. This is why each test drives several request patterns that have distinct lowest set bits. A wrong clear/set precedence can only be seen when both strobes arrive together, so that case is driven explicitly.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef struct packed {
    logic trapSet;
    logic trapClr;
    logic grant;
  } ctrlStrobes_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] TRAP_OPCODE = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] irData,
  input  logic             irLoad,
  input  logic             vecReq,
  input  logic             pendClr,
  output ctrlStrobes_t     strobes,
  output logic             pendingQ
);
  logic trapHit;

  always_comb begin
    trapHit         = irLoad && (irData == TRAP_OPCODE);
    strobes.trapSet = trapHit;
    strobes.trapClr = pendClr && !trapHit;
    strobes.grant   = vecReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pendingQ <= 1'b0;
    else if (strobes.trapSet) pendingQ <= 1'b1;
    else if (strobes.trapClr) pendingQ <= 1'b0;
  end

  assert_trap_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irLoad && irData == TRAP_OPCODE) |=> pendingQ);
  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irLoad && irData == TRAP_OPCODE && pendClr) |=> pendingQ);
  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr && !(irLoad && irData == TRAP_OPCODE)) |=> !pendingQ);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pendingQ && !(irLoad && irData == TRAP_OPCODE)) |=> !pendingQ);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int VEC_W = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               pendingQ,
  input  logic [NUM_REQ-1:0] intReq,
  input  logic               globalEn,
  output logic               takenQ,
  output logic [VEC_W-1:0]   vecQ
);
  logic [NUM_REQ-1:0] maskedReq;
  logic [VEC_W-1:0]   winIdx;
  logic               anyReq;

  always_comb begin
    maskedReq = (globalEn && !pendingQ) ? intReq : '0;
    anyReq    = |maskedReq;
    winIdx    = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (maskedReq[i]) winIdx = VEC_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ <= 1'b0;
      vecQ   <= '0;
    end else if (strobes.grant) begin
      takenQ <= pendingQ || anyReq;
      vecQ   <= pendingQ ? '0 : winIdx;
    end else begin
      takenQ <= 1'b0;
    end
  end

  assert_trap_vector_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grant && pendingQ) |=> (takenQ && vecQ == '0));
  assert_no_take_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.grant |=> !takenQ);
  assert_masked_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grant && !pendingQ && !globalEn) |=> !takenQ);
  assert_low_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grant && !pendingQ && globalEn && intReq[0]) |=> (takenQ && vecQ == VEC_W'(1)));
endmodule

// File: rtl/strap_arbiter.sv
module strap_arbiter
  import strap_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int NUM_REQ = 8,
  parameter logic [OPC_W-1:0] TRAP_OPCODE = '0,
  localparam int VEC_W = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   irData,
  input  logic               irLoad,
  input  logic [NUM_REQ-1:0] intReq,
  input  logic               globalEn,
  input  logic               vecReq,
  input  logic               pendClr,
  output logic               trapPending,
  output logic               intTaken,
  output logic [VEC_W-1:0]   vecIndex
);
  ctrlStrobes_t strobes;
  logic         pendingQ;

  strap_ctrl #(.OPC_W(OPC_W), .TRAP_OPCODE(TRAP_OPCODE)) uCtrl (
    .clk(clk), .rstN(rstN), .irData(irData), .irLoad(irLoad),
    .vecReq(vecReq), .pendClr(pendClr), .strobes(strobes), .pendingQ(pendingQ)
  );

  strap_datapath #(.NUM_REQ(NUM_REQ)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pendingQ(pendingQ),
    .intReq(intReq), .globalEn(globalEn), .takenQ(intTaken), .vecQ(vecIndex)
  );

  assign trapPending = pendingQ;

  assert_trap_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (trapPending && !pendClr) |=> trapPending);
endmodule

// File: tb/strap_arbiter_test.sv
module strap_arbiter_test;
  localparam int NR = 8;
  localparam int VW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irData = 8'h55;
  logic irLoad = 1'b0;
  logic [NR-1:0] intReq = '0;
  logic globalEn = 1'b0;
  logic vecReq = 1'b0;
  logic pendClr = 1'b0;
  logic trapPending, intTaken;
  logic [VW-1:0] vecIndex;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strap_arbiter uut (
    .clk(clk), .rstN(rstN), .irData(irData), .irLoad(irLoad), .intReq(intReq),
    .globalEn(globalEn), .vecReq(vecReq), .pendClr(pendClr),
    .trapPending(trapPending), .intTaken(intTaken), .vecIndex(vecIndex)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One edge: inputs already set at negedge; sample 1ns after posedge, then idle strobes.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    irLoad = 1'b0; vecReq = 1'b0; pendClr = 1'b0; irData = 8'h55;
  endtask

  function automatic int lowIdx(logic [NR-1:0] r);
    for (int i = 0; i < NR; i++) if (r[i]) return i + 1;
    return 0;
  endfunction

  task automatic doClear();
    idle(); pendClr = 1'b1; tick(); idle();
  endtask

  task automatic testReset();
    check("R1 trapPending", trapPending, 0);
    check("R1 intTaken", intTaken, 0);
    check("R1 vecIndex", vecIndex, 0);
  endtask

  task automatic testNoEffect();
    idle(); irData = 8'h00; tick();
    check("R3 opcode without load", trapPending, 0);
    idle(); irData = 8'h3C; irLoad = 1'b1; tick();
    check("R3 other opcode", trapPending, 0);
    idle(); tick();
    check("R3 still clear", trapPending, 0);
  endtask

  task automatic testSetClear();
    idle(); globalEn = 1'b0; irData = 8'h00; irLoad = 1'b1; tick();
    check("R2 trap sets", trapPending, 1);
    check("R11 raised with globalEn=0", trapPending, 1);
    idle(); tick(); tick();
    check("R4 holds", trapPending, 1);
    idle(); irData = 8'h00; irLoad = 1'b1; tick();
    check("R11 retrap keeps pending", trapPending, 1);
    doClear();
    check("R4 cleared", trapPending, 0);
  endtask

  task automatic testSameCycle();
    idle(); irData = 8'h00; irLoad = 1'b1; pendClr = 1'b1; tick();
    check("R5 set wins", trapPending, 1);
    doClear();
    check("R5 later clear", trapPending, 0);
  endtask

  task automatic testTrapVector();
    idle(); irData = 8'h00; irLoad = 1'b1; tick();
    idle(); vecReq = 1'b1; globalEn = 1'b1; intReq = 8'b0000_0100; tick();
    check("R6 taken", intTaken, 1);
    check("R6 index", vecIndex, 0);
    idle(); tick();
    check("R10 pulse ends", intTaken, 0);
    idle(); vecReq = 1'b1; globalEn = 1'b0; intReq = '0; tick();
    check("R6 taken globalEn=0", intTaken, 1);
    check("R6 index globalEn=0", vecIndex, 0);
    doClear();
  endtask

  task automatic testMaskable();
    logic [NR-1:0] pats [4] = '{8'b0000_0001, 8'b1010_0000, 8'b1000_0000, 8'b0011_0110};
    for (int k = 0; k < 4; k++) begin
      idle(); globalEn = 1'b1; intReq = pats[k]; vecReq = 1'b1; tick();
      check("R7 taken", intTaken, 1);
      check("R7 index", vecIndex, lowIdx(pats[k]));
    end
    idle(); intReq = 8'hFF; globalEn = 1'b1; tick();
    check("R10 no vecReq", intTaken, 0);
  endtask

  task automatic testMasked();
    idle(); globalEn = 1'b0; intReq = 8'h12; vecReq = 1'b1; tick();
    check("R8 not taken", intTaken, 0);
    check("R8 index", vecIndex, 0);
    idle(); globalEn = 1'b1; intReq = '0; vecReq = 1'b1; tick();
    check("R9 not taken", intTaken, 0);
    check("R9 index", vecIndex, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1;
    testNoEffect();
    testSetClear();
    testSameCycle();
    testTrapVector();
    testMaskable();
    testMasked();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule